// File: doc/BRIEF.md
# Segment Bank-Switching Memory Mapper

This block sits between a Z80-style CPU bus and two memory sources. The 64K processor space is cut into eight 8K segments, picked by the top three address bits. Any segment can be moved away from the main (HOME) memory onto an alternate bank held in a 128K external SRAM. That alternate bank is one of two 64K halves, DOCK or EX. One global select bit decides which half is live, so every moved segment comes from the same half at any moment.

Two registers written over I/O cycles control the mapping. The first is an 8-bit segment mask. The second is a configuration byte, whose top bit chooses the half. For each memory request the block either asserts `home_sel`, leaving HOME-side decoding to other logic, or enables the SRAM with a 17-bit address. Software can read both registers back over I/O.

Top module: `seg_mmu`

## Requirements
- R1: After reset the mask and the configuration byte are zero. Every memory request then asserts `home_sel`, and register readback returns 0x00.
- R2: During a memory request, the segment number is `addr[15:13]`. If mask bit n is 1 for that segment, `sram_ce`=1 and `home_sel`=0. If the bit is 0, `home_sel`=1 and `sram_ce`=0.
- R3: An I/O write (`iorq`=1, `wr`=1) with `addr[7:0]`=0xF4 loads `wdata` into the mask. `addr[15:8]` is ignored.
- R4: An I/O write with `addr[7:0]`=0xFF loads the configuration byte. Its bit 7 is the half select: 0 = DOCK, 1 = EX. It is driven on `sram_addr[16]`.
- R5: `sram_addr[15:0]` equals the CPU address, so segment n of a half lands on 8K page n of that half.
- R6: When `mreq`=0, `home_sel` and `sram_ce` are both 0.
- R7: An I/O read (`iorq`=1, `rd`=1) of port 0xF4 or 0xFF sets `io_rd_en`=1 and returns that register on `io_rdata`. Any other port gives `io_rd_en`=0 and `io_rdata`=0x00.
- R8: A register write takes effect at the next rising clock edge. A memory request in the same cycle as the write is mapped with the old values.
- R9: I/O writes to other ports, and I/O reads, leave both registers unchanged.
- R10: All eight bits of the configuration byte are stored and read back. Only bit 7 affects the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mreq | input | 1 | Memory request this cycle |
| iorq | input | 1 | I/O request this cycle |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 16 | CPU address (I/O port in the low byte) |
| wdata | input | 8 | Write data for I/O writes |
| home_sel | output | 1 | Memory request served by HOME |
| sram_ce | output | 1 | Memory request served by the alternate SRAM |
| sram_addr | output | 17 | SRAM address {half select, CPU address} |
| io_rd_en | output | 1 | Register readback is driving `io_rdata` |
| io_rdata | output | 8 | Register readback data |

## Verification
The two functions that can meet in one cycle are a mask or configuration write and a memory request that uses the mapping being changed. The bench raises `mreq` together with an I/O write on an address whose low byte is the mask port and whose top bits select an enabled segment. It checks that this cycle still routes to the SRAM under the old mask. It then checks that the next request to the same segment follows the new mask. The half-select write is also followed by a request so that the bank change shows one cycle later.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

   typedef enum logic [1:0] {
      ROUTE_IDLE = 2'd0,
      ROUTE_HOME = 2'd1,
      ROUTE_ALT  = 2'd2
   } route_t;

   typedef struct packed {
      logic wr_mask;
      logic wr_cfg;
      logic rd_mask;
      logic rd_cfg;
   } io_hit_t;

endpackage

// File: rtl/seg_mmu_iodec.sv
module seg_mmu_iodec
   import mmu_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PORT_W    = 8,
   parameter int MASK_PORT = 'hF4,
   parameter int CFG_PORT  = 'hFF
) (
   input  logic              iorq,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output io_hit_t           hit
);

   localparam logic [PORT_W-1:0] MASK_SEL = PORT_W'(MASK_PORT);
   localparam logic [PORT_W-1:0] CFG_SEL  = PORT_W'(CFG_PORT);

   logic [PORT_W-1:0] port;
   logic              io_wr;
   logic              io_rd;
   logic              is_mask;
   logic              is_cfg;

   assign port    = addr[PORT_W-1:0];
   assign io_wr   = iorq & wr;
   assign io_rd   = iorq & rd & ~wr;
   assign is_mask = (port == MASK_SEL);
   assign is_cfg  = (port == CFG_SEL);

   always_comb begin
      hit         = '0;
      hit.wr_mask = io_wr & is_mask;
      hit.wr_cfg  = io_wr & is_cfg;
      hit.rd_mask = io_rd & is_mask;
      hit.rd_cfg  = io_rd & is_cfg;
   end

endmodule

// File: rtl/seg_mmu_regs.sv
module seg_mmu_regs
   import mmu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  io_hit_t           hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] cfg_q
);

   logic [DATA_W-1:0] mask_d;
   logic [DATA_W-1:0] cfg_d;

   assign mask_d = hit.wr_mask ? wdata : mask_q;
   assign cfg_d  = hit.wr_cfg  ? wdata : cfg_q;

   if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q <= '0;
            cfg_q  <= '0;
         end else begin
            mask_q <= mask_d;
            cfg_q  <= cfg_d;
         end
      end
   end else begin : g_srst
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q <= '0;
            cfg_q  <= '0;
         end else begin
            mask_q <= mask_d;
            cfg_q  <= cfg_d;
         end
      end
   end

endmodule

// File: rtl/seg_mmu_map.sv
module seg_mmu_map
   import mmu_pkg::*;
#(
   parameter  int ADDR_W  = 16,
   parameter  int SEG_W   = 3,
   localparam int NSEG    = 1 << SEG_W,
   localparam int SRAM_AW = ADDR_W + 1
) (
   input  logic               mreq,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NSEG-1:0]    mask,
   input  logic               bank,
   output route_t             route,
   output logic [SRAM_AW-1:0] sram_addr
);

   logic [SEG_W-1:0] seg;
   logic [NSEG-1:0]  seg_dec;
   logic [NSEG-1:0]  seg_alt;
   logic             alt_hit;

   assign seg = addr[ADDR_W-1 -: SEG_W];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      assign seg_dec[g] = (seg == SEG_W'(g));
      assign seg_alt[g] = seg_dec[g] & mask[g];
   end

   assign alt_hit = |seg_alt;

   always_comb begin
      if (!mreq)
         route = ROUTE_IDLE;
      else if (alt_hit)
         route = ROUTE_ALT;
      else
         route = ROUTE_HOME;
   end

   assign sram_addr = {bank, addr};

endmodule

// File: rtl/seg_mmu_rdmux.sv
module seg_mmu_rdmux
   import mmu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  io_hit_t           hit,
   input  logic [DATA_W-1:0] mask_q,
   input  logic [DATA_W-1:0] cfg_q,
   output logic              rd_en,
   output logic [DATA_W-1:0] rdata
);

   assign rd_en = hit.rd_mask | hit.rd_cfg;

   always_comb begin
      unique case (1'b1)
         hit.rd_mask: rdata = mask_q;
         hit.rd_cfg:  rdata = cfg_q;
         default:     rdata = '0;
      endcase
   end

endmodule

// File: rtl/seg_mmu.sv
module seg_mmu
   import mmu_pkg::*;
#(
   parameter  int ADDR_W    = 16,
   parameter  int DATA_W    = 8,
   parameter  int SEG_W     = 3,
   parameter  int PORT_W    = 8,
   parameter  int MASK_PORT = 'hF4,
   parameter  int CFG_PORT  = 'hFF,
   parameter  int BANK_BIT  = 7,
   parameter  bit ASYNC_RST = 1'b1,
   localparam int NSEG      = 1 << SEG_W,
   localparam int SRAM_AW   = ADDR_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mreq,
   input  logic               iorq,
   input  logic               rd,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic               home_sel,
   output logic               sram_ce,
   output logic [SRAM_AW-1:0] sram_addr,
   output logic               io_rd_en,
   output logic [DATA_W-1:0]  io_rdata
);

   if (NSEG != DATA_W) begin : g_bad_seg
      $error("seg_mmu: segment count must equal the data width");
   end
   if (BANK_BIT >= DATA_W) begin : g_bad_bank
      $error("seg_mmu: bank bit outside the configuration byte");
   end
   if (PORT_W > ADDR_W || SEG_W >= ADDR_W) begin : g_bad_width
      $error("seg_mmu: address field widths do not fit");
   end
   if (MASK_PORT == CFG_PORT) begin : g_bad_port
      $error("seg_mmu: the two register ports must differ");
   end

   io_hit_t           hit;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] cfg_q;
   route_t            route;

   seg_mmu_iodec #(
      .ADDR_W   (ADDR_W),
      .PORT_W   (PORT_W),
      .MASK_PORT(MASK_PORT),
      .CFG_PORT (CFG_PORT)
   ) u_iodec (
      .iorq(iorq),
      .rd  (rd),
      .wr  (wr),
      .addr(addr),
      .hit (hit)
   );

   seg_mmu_regs #(
      .DATA_W   (DATA_W),
      .ASYNC_RST(ASYNC_RST)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .wdata (wdata),
      .mask_q(mask_q),
      .cfg_q (cfg_q)
   );

   seg_mmu_map #(
      .ADDR_W(ADDR_W),
      .SEG_W (SEG_W)
   ) u_map (
      .mreq     (mreq),
      .addr     (addr),
      .mask     (mask_q[NSEG-1:0]),
      .bank     (cfg_q[BANK_BIT]),
      .route    (route),
      .sram_addr(sram_addr)
   );

   seg_mmu_rdmux #(
      .DATA_W(DATA_W)
   ) u_rdmux (
      .hit   (hit),
      .mask_q(mask_q),
      .cfg_q (cfg_q),
      .rd_en (io_rd_en),
      .rdata (io_rdata)
   );

   assign home_sel = (route == ROUTE_HOME);
   assign sram_ce  = (route == ROUTE_ALT);

endmodule

// File: rtl/seg_mmu_chk.sv
module seg_mmu_chk #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SEG_W     = 3,
   parameter int PORT_W    = 8,
   parameter int MASK_PORT = 'hF4,
   parameter int CFG_PORT  = 'hFF,
   parameter int BANK_BIT  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mreq,
   input logic              iorq,
   input logic              rd,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              home_sel,
   input logic              sram_ce,
   input logic [ADDR_W:0]   sram_addr,
   input logic              io_rd_en,
   input logic [DATA_W-1:0] mask_q,
   input logic [DATA_W-1:0] cfg_q
);

   logic wr_hit_mask;
   logic wr_hit_cfg;

   assign wr_hit_mask = iorq && wr && (addr[PORT_W-1:0] == PORT_W'(MASK_PORT));
   assign wr_hit_cfg  = iorq && wr && (addr[PORT_W-1:0] == PORT_W'(CFG_PORT));

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (mask_q == '0 && cfg_q == '0));

   assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mreq |-> (sram_ce == mask_q[addr[ADDR_W-1 -: SEG_W]]) && (home_sel == !sram_ce));

   assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit_mask |=> mask_q == $past(wdata));

   assert_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ce |-> sram_addr[ADDR_W] == cfg_q[BANK_BIT]);

   assert_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ce |-> sram_addr[ADDR_W-1:0] == addr);

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mreq |-> !home_sel && !sram_ce);

   assert_rd_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      io_rd_en |-> iorq && rd);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit_mask && !wr_hit_cfg |=> $stable(mask_q) && $stable(cfg_q));

   assert_cfg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit_cfg |=> cfg_q == $past(wdata));

endmodule

bind seg_mmu seg_mmu_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .SEG_W    (SEG_W),
   .PORT_W   (PORT_W),
   .MASK_PORT(MASK_PORT),
   .CFG_PORT (CFG_PORT),
   .BANK_BIT (BANK_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mreq     (mreq),
   .iorq     (iorq),
   .rd       (rd),
   .wr       (wr),
   .addr     (addr),
   .wdata    (wdata),
   .home_sel (home_sel),
   .sram_ce  (sram_ce),
   .sram_addr(sram_addr),
   .io_rd_en (io_rd_en),
   .mask_q   (mask_q),
   .cfg_q    (cfg_q)
);

// File: tb/test_seg_mmu.sv
module test_seg_mmu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mreq = 1'b0;
   logic        iorq = 1'b0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        home_sel;
   logic        sram_ce;
   logic [16:0] sram_addr;
   logic        io_rd_en;
   logic [7:0]  io_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seg_mmu i_seg_mmu (
      .clk(clk), .rst_n(rst_n), .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr),
      .addr(addr), .wdata(wdata), .home_sel(home_sel), .sram_ce(sram_ce),
      .sram_addr(sram_addr), .io_rd_en(io_rd_en), .io_rdata(io_rdata)
   );

   // op: 0 memory, 1 I/O write, 2 I/O read, 3 idle
   // {op, addr, wdata, home, ce, saddr, rden, rdata, req}
   localparam int NV = 17;
   localparam logic [57:0] VEC [NV] = '{
      {2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 17'h00000, 1'b0, 8'h00, 4'd1},  // R1
      {2'd0, 16'hE123, 8'h00, 1'b1, 1'b0, 17'h0E123, 1'b0, 8'h00, 4'd1},  // R1
      {2'd1, 16'h12F4, 8'h05, 1'b0, 1'b0, 17'h012F4, 1'b0, 8'h00, 4'd3},  // R3
      {2'd0, 16'h1FFF, 8'h00, 1'b0, 1'b1, 17'h01FFF, 1'b0, 8'h00, 4'd5},  // R5
      {2'd0, 16'h4000, 8'h00, 1'b0, 1'b1, 17'h04000, 1'b0, 8'h00, 4'd2},  // R2
      {2'd0, 16'h2000, 8'h00, 1'b1, 1'b0, 17'h02000, 1'b0, 8'h00, 4'd2},  // R2
      {2'd1, 16'h00FF, 8'h80, 1'b0, 1'b0, 17'h000FF, 1'b0, 8'h00, 4'd4},  // R4
      {2'd0, 16'h4ABC, 8'h00, 1'b0, 1'b1, 17'h14ABC, 1'b0, 8'h00, 4'd4},  // R4
      {2'd1, 16'h00F5, 8'hFF, 1'b0, 1'b0, 17'h100F5, 1'b0, 8'h00, 4'd9},  // R9
      {2'd0, 16'h2000, 8'h00, 1'b1, 1'b0, 17'h12000, 1'b0, 8'h00, 4'd9},  // R9
      {2'd2, 16'h34F4, 8'h00, 1'b0, 1'b0, 17'h134F4, 1'b1, 8'h05, 4'd7},  // R7
      {2'd2, 16'h00FF, 8'h00, 1'b0, 1'b0, 17'h100FF, 1'b1, 8'h80, 4'd7},  // R7
      {2'd2, 16'h00FE, 8'h00, 1'b0, 1'b0, 17'h100FE, 1'b0, 8'h00, 4'd7},  // R7
      {2'd1, 16'h00FF, 8'h3C, 1'b0, 1'b0, 17'h100FF, 1'b0, 8'h00, 4'd10}, // R10
      {2'd2, 16'h00FF, 8'h00, 1'b0, 1'b0, 17'h000FF, 1'b1, 8'h3C, 4'd10}, // R10
      {2'd0, 16'h5555, 8'h00, 1'b0, 1'b1, 17'h05555, 1'b0, 8'h00, 4'd4},  // R4
      {2'd3, 16'h4000, 8'h00, 1'b0, 1'b0, 17'h04000, 1'b0, 8'h00, 4'd6}   // R6
   };

   task automatic drive(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
      addr  = a;
      wdata = d;
      mreq  = (op == 2'd0);
      iorq  = (op == 2'd1) || (op == 2'd2);
      wr    = (op == 2'd1);
      rd    = (op == 2'd0) || (op == 2'd2);
   endtask

   task automatic check(input string tag, input string what, input logic [16:0] got,
                        input logic [16:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      drive(2'd3, 16'h0000, 8'h00);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [57:0] v;
         string       tag;
         v = VEC[i];
         @(negedge clk);
         drive(v[57:56], v[55:40], v[39:32]);
         #5;
         tag = $sformatf("R%0d vec%0d", v[3:0], i);
         check(tag, "home_sel", 17'(home_sel), 17'(v[31]));
         check(tag, "sram_ce", 17'(sram_ce), 17'(v[30]));
         check(tag, "sram_addr", sram_addr, v[29:13]);
         check(tag, "io_rd_en", 17'(io_rd_en), 17'(v[12]));
         check(tag, "io_rdata", 17'(io_rdata), 17'(v[11:4]));
      end

      // R8: mask write and a request in the same cycle; mask is 0x05 here
      @(negedge clk);
      drive(2'd1, 16'h40F4, 8'h00);
      mreq = 1'b1;
      #5;
      check("R8", "same-cycle sram_ce", 17'(sram_ce), 17'd1);
      check("R8", "same-cycle home_sel", 17'(home_sel), 17'd0);
      @(negedge clk);
      drive(2'd0, 16'h4000, 8'h00);
      #5;
      check("R8", "next-cycle home_sel", 17'(home_sel), 17'd1);

      // R2: full mask, top segment, EX half selected
      @(negedge clk);
      drive(2'd1, 16'h00F4, 8'hFF);
      @(negedge clk);
      drive(2'd1, 16'h00FF, 8'h80);
      @(negedge clk);
      drive(2'd0, 16'hFFFF, 8'h00);
      #5;
      check("R2", "seg7 sram_ce", 17'(sram_ce), 17'd1);
      check("R5", "seg7 sram_addr", sram_addr, 17'h1FFFF);

      // R1: reset in mid-run restores HOME mapping and zero readback
      @(negedge clk);
      drive(2'd3, 16'h0000, 8'h00);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive(2'd0, 16'hC000, 8'h00);
      #5;
      check("R1", "post-reset home_sel", 17'(home_sel), 17'd1);
      check("R1", "post-reset sram_ce", 17'(sram_ce), 17'd0);
      @(negedge clk);
      drive(2'd2, 16'h00F4, 8'h00);
      #5;
      check("R1", "post-reset mask readback", 17'(io_rdata), 17'h00);
      @(negedge clk);
      drive(2'd2, 16'h00FF, 8'h00);
      #5;
      check("R1", "post-reset cfg readback", 17'(io_rdata), 17'h00);

      @(negedge clk);
      drive(2'd3, 16'h0000, 8'h00);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule